// File: doc/BRIEF.md
# Word-Serial Binary-Field Multiplier-Squarer

This core computes, in a single run, both the product P = A·B and the square S = A·A of two elements of GF(2^K). The field is defined by a monic degree-K polynomial x^K + H. The datapath is one row of W bit-slices. Every operand and intermediate value is handled in W-bit words, so area grows with W while a run takes (G+1)·NW word steps, where NW = ceil(K/W) and G = ceil(K/2). Each step retires two multiplier bits and two squarer bits.

Operands arrive as a stream of NW beats, most significant word first. Each beat carries one word each of A, B, H (the low K coefficients of the field polynomial) and H' = x^(K+1) mod (x^K + H). Every K-bit value is left-aligned in NW·W bits, and the low NW·W−K pad bits are zero. The running values of A·x^(2i), the two product halves and the two squaring halves recirculate through word-deep delay lines. Bits that cross a word boundary travel through short (NW−1)-deep delay lines. The top coefficient bits are captured once per pass and broadcast to every slice. A final pass folds the odd half in (multiply by x, reduce) and streams P and S out, again most significant word first.

The input handshake is valid/ready. `in_ready` is high only during the load pass, and a missing `in_valid` stalls the whole core. The output handshake is valid/ready. A word held with `out_ready` low stays stable, and the core stalls until it is taken. `start` and `busy` are plain level control pins. Legal parameters are K ≥ 3 and W ≥ 2.

Top module: `gf2_mulsq_core`

## Requirements
- R1: After a run, the NW output words reassemble to P = A·B mod (x^K + H) on `out_p` and S = A·A mod (x^K + H) on `out_s`, for any H including odd K.
- R2: Data words are left-aligned: word NW−1 holds coefficient K−1 in its bit W−1, and the low NW·W−K bits of word 0 are pad bits, driven zero on input and returned zero on output.
- R3: `in_ready` is high only while `busy` is high, and for exactly NW cycles of a run when `in_valid` is held high; one beat is taken on each cycle with both `in_valid` and `in_ready` high.
- R4: With `in_valid` and `out_ready` held high, `out_valid` first rises G·NW+1 rising edges after the edge that samples `start`.
- R5: Exactly NW words are delivered per run, most significant first, with `out_last` set on the last. While `out_valid` is high and `out_ready` low, `out_valid`, `out_p`, `out_s` and `out_last` hold their values.
- R6: Dropping `in_valid` during the load pass keeps `in_ready` high and loses no beat; the results are unchanged.
- R7: A `start` pulse while `busy` is high is ignored: the running computation completes with the correct results.
- R8: `busy` rises on the edge after `start` and is low again by the time the last word is presented.
- R9: After reset, `busy`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Core takes a beat this cycle |
| in_a | input | W | Word of A |
| in_b | input | W | Word of B |
| in_h | input | W | Word of H (low K coefficients of the field polynomial) |
| in_hp | input | W | Word of H' = x^(K+1) mod field polynomial |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_p | output | W | Word of the product |
| out_s | output | W | Word of the square |
| out_last | output | 1 | Marks the least significant (final) word |

## Verification
The assertions assume that the operand stream follows the handshake. A beat is offered only while the run still needs words, and its pad bits and its H' word are consistent with H. The checks cover only handshake stability and the timing of the control pins; arithmetic correctness is left to the result comparison. The stimulus builds every H' from H in the bench, keeps pad bits zero, and stops offering beats after NW have been taken. `in_valid` and `out_ready` are randomly gapped, so the stall rules are exercised without ever leaving the handshake contract.

// File: rtl/mulsq_pkg.sv
package mulsq_pkg;
  // Indices into the bank of word-deep recirculation lines.
  localparam int LN_A  = 0;
  localparam int LN_H  = 1;
  localparam int LN_HP = 2;
  localparam int LN_C  = 3;
  localparam int LN_D  = 4;
  localparam int LN_Q  = 5;
  localparam int LN_R  = 6;
  localparam int N_LINES = 7;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/mulsq_delay.sv
module mulsq_delay #(
  parameter int DW    = 4,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (en) begin
      st[0] <= din;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[DEPTH-1];
endmodule

// File: rtl/mulsq_ctrl.sv
module mulsq_ctrl #(
  parameter int NW = 4,
  parameter int G  = 7,
  localparam int PW  = $clog2(G + 1),
  localparam int WCW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           in_valid,
  input  logic           out_hold,
  output logic           running,
  output logic           adv,
  output logic [PW-1:0]  pass,
  output logic [WCW-1:0] wc,
  output logic           in_load,
  output logic           in_post,
  output logic           first_word,
  output logic           last_word
);
  assign in_load    = (pass == '0);
  assign in_post    = (pass == PW'(G));
  assign first_word = (wc == WCW'(NW - 1));
  assign last_word  = (wc == '0);

  always_comb begin
    if (!running)     adv = 1'b0;
    else if (in_load) adv = in_valid;
    else if (in_post) adv = !out_hold;
    else              adv = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pass    <= '0;
      wc      <= WCW'(NW - 1);
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        pass    <= '0;
        wc      <= WCW'(NW - 1);
      end
    end else if (adv) begin
      if (last_word) begin
        wc <= WCW'(NW - 1);
        if (in_post) running <= 1'b0;
        else         pass    <= pass + 1'b1;
      end else begin
        wc <= wc - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mulsq_main_row.sv
module mulsq_main_row #(
  parameter int W = 4
) (
  input  logic         first,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_prev,
  input  logic [1:0]   lo2,
  input  logic [1:0]   top2,
  input  logic [W-1:0] h,
  input  logic [W-1:0] hp,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] r_in,
  input  logic [3:0]   coef,
  input  logic [3:0]   coef0,
  input  logic [W-1:0] a0w,
  output logic [W-1:0] x,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o
);
  // coef / coef0 order: {a odd, a even, b odd, b even}
  for (genvar j = 0; j < W; j++) begin : g_pe
    logic sh;
    if (j >= 2) begin : g_in
      assign sh = a_prev[j-2];
    end else begin : g_edge
      assign sh = lo2[j];
    end
    assign x[j]   = first ? a_in[j] : (sh ^ (top2[0] & h[j]) ^ (top2[1] & hp[j]));
    assign c_o[j] = !first & (c_in[j] ^ (coef[0] & x[j]) ^ (coef0[0] & a0w[j]));
    assign d_o[j] = !first & (d_in[j] ^ (coef[1] & x[j]) ^ (coef0[1] & a0w[j]));
    assign q_o[j] = !first & (q_in[j] ^ (coef[2] & x[j]) ^ (coef0[2] & a0w[j]));
    assign r_o[j] = !first & (r_in[j] ^ (coef[3] & x[j]) ^ (coef0[3] & a0w[j]));
  end
endmodule

// File: rtl/mulsq_post_row.sv
module mulsq_post_row #(
  parameter int W = 4
) (
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic [W-1:0] q,
  input  logic [W-1:0] r,
  input  logic [W-1:0] h,
  input  logic         dtop,
  input  logic         rtop,
  input  logic         dlo,
  input  logic         rlo,
  output logic [W-1:0] p,
  output logic [W-1:0] s
);
  for (genvar j = 0; j < W; j++) begin : g_pe
    logic dsh, rsh;
    if (j >= 1) begin : g_in
      assign dsh = d[j-1];
      assign rsh = r[j-1];
    end else begin : g_edge
      assign dsh = dlo;
      assign rsh = rlo;
    end
    assign p[j] = c[j] ^ dsh ^ (dtop & h[j]);
    assign s[j] = q[j] ^ rsh ^ (rtop & h[j]);
  end
endmodule

// File: rtl/gf2_mulsq_core.sv
module gf2_mulsq_core
  import mulsq_pkg::*;
#(
  parameter int K = 13,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         busy,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_h,
  input  logic [W-1:0] in_hp,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_p,
  output logic [W-1:0] out_s,
  output logic         out_last
);
  localparam int NW  = cdiv(K, W);
  localparam int KP  = NW * W;
  localparam int PAD = KP - K;
  localparam int G   = (K + 1) / 2;
  localparam int PW  = $clog2(G + 1);
  localparam int WCW = (NW > 1) ? $clog2(NW) : 1;

  logic           running, adv, in_load, in_post, first_word, last_word;
  logic [PW-1:0]  pass;
  logic [WCW-1:0] wc;

  mulsq_ctrl #(.NW(NW), .G(G)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_hold(out_valid && !out_ready), .running(running), .adv(adv),
    .pass(pass), .wc(wc), .in_load(in_load), .in_post(in_post),
    .first_word(first_word), .last_word(last_word)
  );

  assign busy     = running;
  assign in_ready = running && in_load;

  // Recirculation lines, one word per step, NW words deep.
  logic [N_LINES-1:0][W-1:0] ln_in, ln_out;
  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    mulsq_delay #(.DW(W), .DEPTH(NW)) u_line (
      .clk(clk), .rst_n(rst_n), .en(adv), .din(ln_in[n]), .dout(ln_out[n])
    );
  end

  // Boundary-bit lines, NW-1 deep: two A bits, one D bit, one R bit.
  logic [1:0] lo_in, lo_out, dr_in, dr_out;
  if (NW > 1) begin : g_edge_lines
    mulsq_delay #(.DW(2), .DEPTH(NW - 1)) u_lo (
      .clk(clk), .rst_n(rst_n), .en(adv), .din(lo_in), .dout(lo_out));
    mulsq_delay #(.DW(2), .DEPTH(NW - 1)) u_dr (
      .clk(clk), .rst_n(rst_n), .en(adv), .din(dr_in), .dout(dr_out));
  end else begin : g_no_edge
    assign lo_out = 2'b00;
    assign dr_out = 2'b00;
  end

  // Operand bit registers, filled during the load pass.
  logic [KP-1:0] op_a, op_b;
  logic [3:0]    bcast_q;   // {r top, d top, a top two}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a    <= '0;
      op_b    <= '0;
      bcast_q <= '0;
    end else if (adv) begin
      if (in_load) begin
        op_a <= KP'({op_a, in_a});
        op_b <= KP'({op_b, in_b});
      end
      if (first_word)
        bcast_q <= {ln_out[LN_R][W-1], ln_out[LN_D][W-1], ln_out[LN_A][W-1:W-2]};
    end
  end

  logic [K-1:0] a_bits, b_bits;
  assign a_bits = K'(op_a >> PAD);
  assign b_bits = K'(op_b >> PAD);

  function automatic logic pick(input logic [K-1:0] v, input int idx);
    logic r;
    r = 1'b0;
    for (int j = 0; j < K; j++) if (j == idx) r = v[j];
    return r;
  endfunction

  logic [3:0]   coef, coef0;
  logic [W-1:0] a0w;
  always_comb begin
    int i0;
    i0 = 2 * int'(pass);
    coef  = {pick(a_bits, i0 + 1), pick(a_bits, i0), pick(b_bits, i0 + 1), pick(b_bits, i0)};
    coef0 = (pass == PW'(1)) ? {a_bits[1], a_bits[0], b_bits[1], b_bits[0]} : 4'b0000;
    a0w   = '0;
    for (int n = 0; n < NW; n++) if (wc == WCW'(n)) a0w = op_a[n*W +: W];
  end

  logic [W-1:0] h_w, hp_w, x_w, c_w, d_w, q_w, r_w, p_w, s_w;
  logic [1:0]   top2, lo2;
  assign h_w  = in_load ? in_h  : ln_out[LN_H];
  assign hp_w = in_load ? in_hp : ln_out[LN_HP];
  assign top2 = first_word ? ln_out[LN_A][W-1:W-2] : bcast_q[1:0];
  assign lo2  = last_word ? 2'b00 : lo_out;

  mulsq_main_row #(.W(W)) u_main (
    .first(in_load), .a_in(in_a), .a_prev(ln_out[LN_A]), .lo2(lo2), .top2(top2),
    .h(h_w), .hp(hp_w), .c_in(ln_out[LN_C]), .d_in(ln_out[LN_D]),
    .q_in(ln_out[LN_Q]), .r_in(ln_out[LN_R]), .coef(coef), .coef0(coef0),
    .a0w(a0w), .x(x_w), .c_o(c_w), .d_o(d_w), .q_o(q_w), .r_o(r_w)
  );

  assign ln_in[LN_A]  = x_w;
  assign ln_in[LN_H]  = h_w;
  assign ln_in[LN_HP] = hp_w;
  assign ln_in[LN_C]  = c_w;
  assign ln_in[LN_D]  = d_w;
  assign ln_in[LN_Q]  = q_w;
  assign ln_in[LN_R]  = r_w;
  assign lo_in        = x_w[W-1:W-2];
  assign dr_in        = {r_w[W-1], d_w[W-1]};

  logic dtop, rtop;
  assign dtop = first_word ? ln_out[LN_D][W-1] : bcast_q[2];
  assign rtop = first_word ? ln_out[LN_R][W-1] : bcast_q[3];

  mulsq_post_row #(.W(W)) u_post (
    .c(ln_out[LN_C]), .d(ln_out[LN_D]), .q(ln_out[LN_Q]), .r(ln_out[LN_R]),
    .h(ln_out[LN_H]), .dtop(dtop), .rtop(rtop),
    .dlo(!last_word && dr_out[0]), .rlo(!last_word && dr_out[1]),
    .p(p_w), .s(s_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_p     <= '0;
      out_s     <= '0;
    end else if (adv && in_post) begin
      out_valid <= 1'b1;
      out_last  <= last_word;
      out_p     <= p_w;
      out_s     <= s_w;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mulsq_chk.sv
module mulsq_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_last,
  input logic [W-1:0] out_p,
  input logic [W-1:0] out_s
);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_s) && $stable(out_last));
  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  // R6
  in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready);
  // R8
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid && out_last) |-> !busy);
  // R3
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> busy);
endmodule

bind gf2_mulsq_core mulsq_chk #(.W(W)) u_mulsq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_p(out_p), .out_s(out_s)
);

// File: tb/test_gf2_mulsq_core.sv
module test_gf2_mulsq_core;
  localparam int K   = 13;
  localparam int W   = 4;
  localparam int NW  = (K + W - 1) / W;
  localparam int KP  = NW * W;
  localparam int PAD = KP - K;
  localparam int G   = (K + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic busy, in_ready, out_valid, out_last;
  logic [W-1:0] in_a = '0, in_b = '0, in_h = '0, in_hp = '0, out_p, out_s;

  gf2_mulsq_core #(.K(K), .W(W)) i_gf2_mulsq_core (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .in_h(in_h), .in_hp(in_hp), .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p), .out_s(out_s), .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  function automatic logic [K-1:0] xt(input logic [K-1:0] v, input logic [K-1:0] h);
    return (v << 1) ^ (v[K-1] ? h : '0);
  endfunction

  function automatic logic [K-1:0] mulmod(input logic [K-1:0] a, input logic [K-1:0] b,
                                          input logic [K-1:0] h);
    logic [K-1:0] r;
    r = '0;
    for (int i = K - 1; i >= 0; i--) begin
      r = xt(r, h);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic run_op(input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] h,
                        input int in_pct, input int out_pct, input bit mid_start,
                        input bit time_it);
    logic [KP-1:0] ap, bp, hpad, hppad, pacc, sacc, pexp, sexp;
    int beat, got, n, first, rdy_cnt;
    bit done, take;
    ap    = KP'(a) << PAD;
    bp    = KP'(b) << PAD;
    hpad  = KP'(h) << PAD;
    hppad = KP'(xt(h, h)) << PAD;
    pexp  = KP'(mulmod(a, b, h)) << PAD;
    sexp  = KP'(mulmod(a, a, h)) << PAD;
    pacc = '0; sacc = '0;
    beat = 0; got = 0; n = 0; first = -1; rdy_cnt = 0; done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 3000) begin
      if (in_ready) rdy_cnt++;
      in_valid = (beat < NW) && (($urandom % 100) >= in_pct);
      in_a  = W'(ap    >> ((NW - 1 - beat) * W));
      in_b  = W'(bp    >> ((NW - 1 - beat) * W));
      in_h  = W'(hpad  >> ((NW - 1 - beat) * W));
      in_hp = W'(hppad >> ((NW - 1 - beat) * W));
      out_ready = (($urandom % 100) >= out_pct);
      start = mid_start && (n == 10);
      take = in_valid && in_ready;
      if (out_valid && first < 0) first = n;
      if (out_valid && out_ready) begin
        pacc = KP'({pacc, out_p});
        sacc = KP'({sacc, out_s});
        got++;
        if (out_last) done = 1;
      end
      @(negedge clk);
      n++;
      if (take) beat++;
    end
    in_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
    // R1 and R2: full padded words compared, so pad bits must come back zero
    chk(pacc == pexp, "R1/R2 product", int'(pacc), int'(pexp));
    chk(sacc == sexp, "R1/R2 square", int'(sacc), int'(sexp));
    // R5: word count ends on out_last
    chk(got == NW, "R5 word count", got, NW);
    if (time_it) begin
      chk(first == G * NW + 1, "R4 first output latency", first, G * NW + 1);
      chk(rdy_cnt == NW, "R3 ready cycles", rdy_cnt, NW);
    end
    if (mid_start) chk(!busy, "R7 no restart after ignored start", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_up();
  end

  initial begin
    logic [K-1:0] ra, rb, rh;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    chk(in_ready == 1'b0, "R9 in_ready after reset", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy idle", int'(busy), 0);

    // R4, R3, R8: unstalled timing
    run_op(13'h1a5b, 13'h0c33, 13'h001b, 0, 0, 0, 1);
    chk(busy == 1'b0, "R8 idle after run", int'(busy), 0);
    // Directed corners (R1)
    run_op('0, 13'h1fff, 13'h001b, 0, 0, 0, 0);
    run_op(13'h0001, 13'h0001, 13'h001b, 0, 0, 0, 0);
    run_op(13'h1fff, 13'h1fff, 13'h1fff, 0, 0, 0, 0);
    run_op(13'h1000, 13'h1000, 13'h0000, 0, 0, 0, 0);
    run_op(13'h1800, 13'h1001, 13'h0009, 0, 0, 0, 1);
    // R6: input gaps, R5: output back-pressure
    run_op(13'h0abc, 13'h1357, 13'h001b, 60, 0, 0, 0);
    run_op(13'h1357, 13'h0abc, 13'h0039, 0, 70, 0, 0);
    // R7: start pulsed mid-run
    run_op(13'h0f0f, 13'h10f1, 13'h001b, 30, 30, 1, 0);
    for (int t = 0; t < 24; t++) begin
      ra = K'($urandom);
      rb = K'($urandom);
      rh = K'($urandom);
      run_op(ra, rb, rh, (t % 3) * 30, ((t / 3) % 3) * 30, (t % 5) == 0, 0);
    end
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule